// File: doc/BRIEF.md
# Address Translation Buffer with Table Walk

This block turns 32-bit virtual addresses into physical addresses for a 4 KB page size, and checks whether the requested kind of access is allowed. It keeps 64 recently used translations in a fully associative store. Every entry holds a valid bit, a dirty bit, a reference bit, three permission bits, a 20-bit virtual page tag and a 20-bit physical page number. The tags of all valid entries are compared in parallel. On a hit the response appears one cycle after the request is accepted.

On a miss, the block stalls the requester and reads one 32-bit word from a single-level page table in memory. The word's address is the table base input plus four times the virtual page number. A valid table word is installed into the store, and the waiting request then completes as a normal lookup. An invalid table word ends the request with a page fault and installs nothing. When the store is full, an entry is replaced using a clock-style approximation of least-recently-used order, driven by the reference bits. A flush input invalidates every entry in one cycle.

Top module: `xlat_tlb`

## Requirements
- R1: After reset the store is empty. `rsp_valid_o` and `mem_req_o` are low, and `req_ready_o` stays low while no request is presented.
- R2: A lookup that misses holds `req_ready_o` low and issues exactly one single-cycle word read at `ptbr_i + 4*VA[31:12]`. `req_ready_o` stays low until the read data has returned.
- R3: A request that hits the store is accepted in the cycle it is presented. In the next cycle the response carries `rsp_valid_o=1` and `rsp_hit_o=1`, and no memory read is made. The physical address is the stored page number in bits 31..12, with VA[11:0] passed through unchanged in bits 11..0.
- R4: A request that needed a walk completes with `rsp_hit_o=0` once the fetched entry has been installed. The physical page number comes from bits 19..0 of the table word, and table-word bits 27..20 are ignored.
- R5: When table-word bit 31 is 0, the request completes with `rsp_page_fault_o=1`, `rsp_hit_o=0` and a zero address. Nothing is installed, so repeating the request walks again.
- R6: Permission bits are taken from the table word: bit 30 allows read, bit 29 allows write, bit 28 allows execute. `req_kind_i` is encoded 0 read, 1 write, 2 execute, and 3 is always refused. A request its page does not allow completes with `rsp_prot_fault_o=1` and a zero address.
- R7: A new entry always goes into the lowest-numbered invalid slot while one exists. As a result, 64 pages loaded into an emptied store all stay resident.
- R8: With every slot valid, the victim is the first slot with a clear reference bit, searched from a rotating pointer. The pointer then moves past the victim. If every reference bit is set, all of them are cleared and the pointer slot is used. Every accepted access sets the reference bit of its entry.
- R9: A flush invalidates all entries in one cycle. While `flush_i` is high, `req_ready_o` is low.
- R10: Each accepted request produces exactly one response, in the cycle after acceptance. `rsp_valid_o` is never high in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush_i | input | 1 | Invalidate all entries |
| ptbr_i | input | 32 | Page-table base address |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle |
| req_vaddr_i | input | 32 | Virtual address |
| req_kind_i | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid_o | output | 1 | Response valid |
| rsp_paddr_o | output | 32 | Physical address, zero on any fault |
| rsp_hit_o | output | 1 | Served without a walk |
| rsp_page_fault_o | output | 1 | Page table entry invalid |
| rsp_prot_fault_o | output | 1 | Access kind not permitted |
| mem_req_o | output | 1 | Single-cycle table read strobe |
| mem_addr_o | output | 32 | Table word address |
| mem_rvalid_i | input | 1 | Table read data valid |
| mem_rdata_i | input | 32 | Table read data |

## Verification
A corrupted tag, valid bit or page number shows up as an unexpected walk, or as a wrong address on the very next response. Lost permission bits surface as a protection fault on the first access of the wrong kind. A faulty reference bit or pointer does not show at once. It shows several replacements later, when the wrong page is evicted and a request that should hit starts a walk instead. The bench therefore follows the eviction order over a sequence of misses.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
    localparam int VA_W     = 32;
    localparam int OFFS_W   = 12;
    localparam int VPN_W    = VA_W - OFFS_W;
    localparam int PPN_W    = 20;
    localparam int PA_W     = PPN_W + OFFS_W;
    localparam int PTE_W    = 32;
    localparam int RIGHTS_W = 3;
    localparam int PTE_V_BIT  = 31;
    localparam int PTE_RT_HI  = 30;
    localparam int PTE_RT_LO  = 28;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_FAULT
    } walk_state_e;

    // rights: [2] read, [1] write, [0] execute
    typedef struct packed {
        logic                valid;
        logic                dirty;
        logic                refd;
        logic [RIGHTS_W-1:0] rights;
        logic [VPN_W-1:0]    tag;
        logic [PPN_W-1:0]    ppn;
    } tlb_entry_t;
endpackage

// File: rtl/xlat_perm.sv
`timescale 1ns/1ps
module xlat_perm
    import xlat_pkg::*;
(
    input  logic [RIGHTS_W-1:0] rights_i,
    input  acc_kind_e           kind_i,
    output logic                allow_o
);
    always_comb begin
        unique case (kind_i)
            ACC_READ:  allow_o = rights_i[2];
            ACC_WRITE: allow_o = rights_i[1];
            ACC_EXEC:  allow_o = rights_i[0];
            default:   allow_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/xlat_match.sv
`timescale 1ns/1ps
module xlat_match
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [VPN_W-1:0]   tags_i [ENTRIES],
    input  logic [VPN_W-1:0]   vpn_i,
    output logic               hit_o,
    output logic [IDX_W-1:0]   idx_o
);
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid_i[g] && (tags_i[g] == vpn_i);
    end

    assign hit_o = |match;

    always_comb begin
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/xlat_victim.sv
`timescale 1ns/1ps
module xlat_victim #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [ENTRIES-1:0] ref_i,
    input  logic [IDX_W-1:0]   ptr_i,
    output logic [IDX_W-1:0]   victim_o,
    output logic               by_scan_o,
    output logic               clear_refs_o
);
    logic             has_free;
    logic [IDX_W-1:0] free_idx;
    logic             scan_found;
    logic [IDX_W-1:0] scan_idx;
    logic [IDX_W-1:0] pos;

    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        scan_found = 1'b0;
        scan_idx   = ptr_i;
        pos        = '0;
        // walk backwards so the slot nearest the pointer wins
        for (int k = ENTRIES - 1; k >= 0; k--) begin
            pos = ptr_i + IDX_W'(k);
            if (!ref_i[pos]) begin
                scan_found = 1'b1;
                scan_idx   = pos;
            end
        end
        victim_o     = has_free ? free_idx : (scan_found ? scan_idx : ptr_i);
        by_scan_o    = !has_free;
        clear_refs_o = !has_free && !scan_found;
    end
endmodule

// File: rtl/xlat_tlb.sv
`timescale 1ns/1ps
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [VA_W-1:0]   ptbr_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [VA_W-1:0]   req_vaddr_i,
    input  logic [1:0]        req_kind_i,
    output logic              rsp_valid_o,
    output logic [PA_W-1:0]   rsp_paddr_o,
    output logic              rsp_hit_o,
    output logic              rsp_page_fault_o,
    output logic              rsp_prot_fault_o,
    output logic              mem_req_o,
    output logic [VA_W-1:0]   mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [PTE_W-1:0]  mem_rdata_i
);
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int PAD_W  = VA_W - VPN_W - 2;

    typedef struct packed {
        walk_state_e      st;
        logic [VPN_W-1:0] wvpn;
        logic [IDX_W-1:0] ptr;
        logic             walked;
        logic             rsp_valid;
        logic [PA_W-1:0]  rsp_paddr;
        logic             rsp_hit;
        logic             rsp_pf;
        logic             rsp_prot;
    } ctl_t;

    ctl_t       c_q, c_d;
    tlb_entry_t ent_q [ENTRIES];
    tlb_entry_t ent_d [ENTRIES];

    logic [ENTRIES-1:0] valid_v;
    logic [ENTRIES-1:0] ref_v;
    logic [VPN_W-1:0]   tags_v [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign valid_v[g] = ent_q[g].valid;
        assign ref_v[g]   = ent_q[g].refd;
        assign tags_v[g]  = ent_q[g].tag;
    end

    logic [VPN_W-1:0]  req_vpn;
    logic [OFFS_W-1:0] req_off;
    assign req_vpn = req_vaddr_i[VA_W-1:OFFS_W];
    assign req_off = req_vaddr_i[OFFS_W-1:0];

    logic             lk_hit;
    logic [IDX_W-1:0] lk_idx;
    logic             allow;
    logic [IDX_W-1:0] victim;
    logic             by_scan;
    logic             clear_refs;
    acc_kind_e        kind;

    assign kind = acc_kind_e'(req_kind_i);

    xlat_match #(.ENTRIES(ENTRIES)) u_match (
        .valid_i (valid_v),
        .tags_i  (tags_v),
        .vpn_i   (req_vpn),
        .hit_o   (lk_hit),
        .idx_o   (lk_idx)
    );

    xlat_perm u_perm (
        .rights_i (ent_q[lk_idx].rights),
        .kind_i   (kind),
        .allow_o  (allow)
    );

    xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
        .valid_i      (valid_v),
        .ref_i        (ref_v),
        .ptr_i        (c_q.ptr),
        .victim_o     (victim),
        .by_scan_o    (by_scan),
        .clear_refs_o (clear_refs)
    );

    logic accept;
    assign req_ready_o = !flush_i &&
                         (((c_q.st == ST_IDLE) && lk_hit) || (c_q.st == ST_FAULT));
    assign accept      = req_valid_i && req_ready_o;

    logic [7:0] unused_pte_bits;
    assign unused_pte_bits = mem_rdata_i[27:20];

    always_comb begin
        c_d   = c_q;
        ent_d = ent_q;
        c_d.rsp_valid = 1'b0;
        c_d.rsp_hit   = 1'b0;
        c_d.rsp_pf    = 1'b0;
        c_d.rsp_prot  = 1'b0;
        c_d.rsp_paddr = '0;

        unique case (c_q.st)
            ST_IDLE: begin
                if (accept) begin
                    c_d.rsp_valid = 1'b1;
                    c_d.rsp_hit   = !c_q.walked;
                    c_d.walked    = 1'b0;
                    ent_d[lk_idx].refd = 1'b1;
                    if (allow) begin
                        c_d.rsp_paddr = {ent_q[lk_idx].ppn, req_off};
                        if (kind == ACC_WRITE) ent_d[lk_idx].dirty = 1'b1;
                    end else begin
                        c_d.rsp_prot = 1'b1;
                    end
                end else if (req_valid_i && !flush_i && !lk_hit) begin
                    c_d.st   = ST_FETCH;
                    c_d.wvpn = req_vpn;
                end
            end
            ST_FETCH: begin
                c_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rvalid_i) begin
                    if (mem_rdata_i[PTE_V_BIT]) begin
                        if (clear_refs) begin
                            for (int i = 0; i < ENTRIES; i++) ent_d[i].refd = 1'b0;
                        end
                        ent_d[victim] = '{valid:  1'b1,
                                          dirty:  1'b0,
                                          refd:   1'b0,
                                          rights: mem_rdata_i[PTE_RT_HI:PTE_RT_LO],
                                          tag:    c_q.wvpn,
                                          ppn:    mem_rdata_i[PPN_W-1:0]};
                        if (by_scan) c_d.ptr = victim + IDX_W'(1);
                        c_d.walked = 1'b1;
                        c_d.st     = ST_IDLE;
                    end else begin
                        c_d.st = ST_FAULT;
                    end
                end
            end
            ST_FAULT: begin
                if (accept) begin
                    c_d.rsp_valid = 1'b1;
                    c_d.rsp_pf    = 1'b1;
                    c_d.walked    = 1'b0;
                    c_d.st        = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase

        if (flush_i) begin
            for (int i = 0; i < ENTRIES; i++) ent_d[i].valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, default: '0};
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
        end else begin
            c_q <= c_d;
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= ent_d[i];
        end
    end

    assign rsp_valid_o      = c_q.rsp_valid;
    assign rsp_paddr_o      = c_q.rsp_paddr;
    assign rsp_hit_o        = c_q.rsp_hit;
    assign rsp_page_fault_o = c_q.rsp_pf;
    assign rsp_prot_fault_o = c_q.rsp_prot;
    assign mem_req_o        = (c_q.st == ST_FETCH);
    assign mem_addr_o       = ptbr_i + {{PAD_W{1'b0}}, c_q.wvpn, 2'b00};
endmodule

// File: rtl/xlat_tlb_chk.sv
`timescale 1ns/1ps
module xlat_tlb_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        flush_i,
    input logic        req_valid_i,
    input logic        req_ready_o,
    input logic [31:0] req_vaddr_i,
    input logic        rsp_valid_o,
    input logic [31:0] rsp_paddr_o,
    input logic        rsp_hit_o,
    input logic        rsp_page_fault_o,
    input logic        rsp_prot_fault_o,
    input logic        mem_req_o
);
    a_r10_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> rsp_valid_o);

    a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid_i && req_ready_o) |=> !rsp_valid_o);

    a_r2_fetch_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);

    a_r2_stalled_during_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !req_ready_o);

    a_r9_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> !req_ready_o);

    a_r5_page_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_page_fault_o) |->
            (!rsp_hit_o && !rsp_prot_fault_o && rsp_paddr_o == 32'd0));

    a_r6_prot_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_prot_fault_o) |-> (rsp_paddr_o == 32'd0));

    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=>
            (rsp_page_fault_o || rsp_prot_fault_o ||
             rsp_paddr_o[11:0] == $past(req_vaddr_i[11:0])));
endmodule

bind xlat_tlb xlat_tlb_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .flush_i          (flush_i),
    .req_valid_i      (req_valid_i),
    .req_ready_o      (req_ready_o),
    .req_vaddr_i      (req_vaddr_i),
    .rsp_valid_o      (rsp_valid_o),
    .rsp_paddr_o      (rsp_paddr_o),
    .rsp_hit_o        (rsp_hit_o),
    .rsp_page_fault_o (rsp_page_fault_o),
    .rsp_prot_fault_o (rsp_prot_fault_o),
    .mem_req_o        (mem_req_o)
);

// File: tb/xlat_tlb_tb_top.sv
`timescale 1ns/1ps
module xlat_tlb_tb_top;
    import xlat_pkg::*;

    localparam logic [31:0] PTBR = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_hit, rsp_pf, rsp_prot;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_checks = 0;
    int n_errors = 0;
    int mem_reads = 0;
    logic [31:0] last_addr = '0;

    always #2.5 clk = ~clk;

    xlat_tlb dut_i (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .ptbr_i(PTBR),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_vaddr_i(req_vaddr), .req_kind_i(req_kind),
        .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_hit_o(rsp_hit),
        .rsp_page_fault_o(rsp_pf), .rsp_prot_fault_o(rsp_prot),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
    );

    // table contents: pages from F0000 up are unmapped; rights by low two bits
    function automatic logic [31:0] pte_of(input logic [19:0] vpn);
        logic [2:0] r;
        case (vpn[1:0])
            2'd0: r = 3'b100;
            2'd1: r = 3'b110;
            2'd2: r = 3'b001;
            default: r = 3'b111;
        endcase
        return {(vpn < 20'hF0000), r, 8'hC3, vpn ^ 20'h5A5A5};
    endfunction

    function automatic bit allowed(input logic [19:0] vpn, input logic [1:0] kind);
        logic [31:0] p = pte_of(vpn);
        case (kind)
            2'd0: return p[30];
            2'd1: return p[29];
            2'd2: return p[28];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [1:0] ok_kind(input logic [19:0] vpn);
        return (vpn[1:0] == 2'd2) ? 2'd2 : 2'd0;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory model: two cycles of latency after the strobe
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                logic [31:0] a;
                a = mem_addr;
                mem_reads++;
                last_addr = a;
                repeat (2) @(negedge clk);
                mem_rdata  = pte_of(20'((a - PTBR) >> 2));
                mem_rvalid = 1'b1;
                @(negedge clk);
                mem_rvalid = 1'b0;
            end
        end
    end

    // called and returns at negedge + 1
    task automatic access(input logic [19:0] vpn, input logic [11:0] off,
                          input logic [1:0] kind, input bit exp_walk, input string req);
        int r0;
        int waits;
        logic [31:0] p;
        r0 = mem_reads;
        waits = 0;
        req_valid = 1'b1;
        req_vaddr = {vpn, off};
        req_kind  = kind;
        #1;
        while (!req_ready && waits < 50) begin
            @(negedge clk); #1;
            waits++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        p = pte_of(vpn);
        check(req, "walk count", 32'(mem_reads - r0), 32'(exp_walk));
        check(req, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
        if (exp_walk) begin
            check(req, "table address", last_addr, PTBR + {10'd0, vpn, 2'b00});
            check(req, "stall cycles>=2", {31'd0, waits >= 2}, 32'd1);
        end
        if (!p[31]) begin
            check(req, "page fault", {31'd0, rsp_pf}, 32'd1);
            check(req, "hit", {31'd0, rsp_hit}, 32'd0);
            check(req, "paddr", rsp_paddr, 32'd0);
        end else begin
            check(req, "hit", {31'd0, rsp_hit}, {31'd0, !exp_walk});
            check(req, "page fault", {31'd0, rsp_pf}, 32'd0);
            if (allowed(vpn, kind)) begin
                check(req, "prot", {31'd0, rsp_prot}, 32'd0);
                check(req, "paddr", rsp_paddr, {p[19:0], off});
            end else begin
                check(req, "prot", {31'd0, rsp_prot}, 32'd1);
                check(req, "paddr", rsp_paddr, 32'd0);
            end
        end
        @(negedge clk); #1;
        check("R10", "rsp_valid drops", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_reset;
        check("R1", "ready idle", {31'd0, req_ready}, 32'd0);
        check("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R1", "mem_req", {31'd0, mem_req}, 32'd0);
    endtask

    task automatic t_miss_hit;
        access(20'h00010, 12'h123, 2'd0, 1'b1, "R4");
        access(20'h00010, 12'hABC, 2'd0, 1'b0, "R3");
        access(20'h00011, 12'h000, 2'd1, 1'b1, "R2");
        access(20'h00011, 12'hFFF, 2'd1, 1'b0, "R3");
    endtask

    task automatic t_perms;
        access(20'h00010, 12'h010, 2'd1, 1'b0, "R6");
        access(20'h00010, 12'h020, 2'd2, 1'b0, "R6");
        access(20'h00012, 12'h030, 2'd0, 1'b1, "R6");
        access(20'h00012, 12'h040, 2'd2, 1'b0, "R6");
        access(20'h00013, 12'h050, 2'd3, 1'b1, "R6");
        access(20'h00013, 12'h060, 2'd1, 1'b0, "R6");
    endtask

    task automatic t_page_fault;
        access(20'hF0001, 12'h111, 2'd0, 1'b1, "R5");
        access(20'hF0001, 12'h111, 2'd0, 1'b1, "R5");
    endtask

    task automatic t_flush;
        req_valid = 1'b1;
        req_vaddr = {20'h00010, 12'h000};
        req_kind  = 2'd0;
        flush = 1'b1;
        #1;
        check("R9", "ready during flush", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        flush = 1'b0;
        req_valid = 1'b0;
        #1;
        access(20'h00010, 12'h321, 2'd0, 1'b1, "R9");
    endtask

    task automatic t_fill_free;
        flush = 1'b1;
        @(negedge clk); #1;
        flush = 1'b0;
        for (int i = 0; i < 64; i++)
            access(20'h00100 + 20'(i), 12'(i), ok_kind(20'h00100 + 20'(i)), 1'b1, "R7");
        for (int i = 0; i < 64; i++)
            access(20'h00100 + 20'(i), 12'(i * 3), ok_kind(20'h00100 + 20'(i)), 1'b0, "R7");
    endtask

    task automatic t_replace;
        access(20'h00200, 12'h5, 2'd0, 1'b1, "R8");
        access(20'h00101, 12'h6, 2'd0, 1'b0, "R8");
        access(20'h00100, 12'h7, 2'd0, 1'b1, "R8");
        access(20'h00102, 12'h8, 2'd2, 1'b1, "R8");
        access(20'h00104, 12'h9, 2'd0, 1'b0, "R8");
        access(20'h00103, 12'hA, 2'd0, 1'b1, "R8");
        access(20'h00200, 12'hB, 2'd0, 1'b0, "R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_miss_hit();
        t_perms();
        t_page_fault();
        t_flush();
        t_fill_free();
        t_replace();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule